// File: doc/BRIEF.md
# Alarm Match and Interrupt Flag Unit

This block sits beside a real-time clock's time counters. It holds three alarm bytes, one each for seconds, minutes and hours. At every update-ended pulse it compares them with the current time values. It also accepts a periodic pulse from the rate generator. Each of the three events sets a flag. The flags are masked by per-source enable bits, and the result drives one active-high interrupt line.

A host reaches the block through a byte-wide register port. Through it the host programs the alarm bytes and the enable bits, and it reads the flag register. Reading the flag register also acknowledges it: that read clears every flag. Time counting and rate generation are done elsewhere and reach this block only as input values and single-cycle pulses.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After synchronous reset, all flags, alarm bytes and enable bits are zero, and `irq` is low.
- R2: A write with `wr_en` high stores `wdata` at one of these addresses: 1 (seconds alarm), 3 (minutes alarm), 5 (hours alarm), or 11 (control, where bits 6, 5 and 4 are the periodic, alarm and update enables). A read with `rd_en` high returns the stored value combinationally. Unused control bits, unmapped addresses and an idle port (`rd_en` low) read as zero.
- R3: An alarm byte whose bits 7 and 6 are both set matches any value of its time field. Any other alarm byte matches only when it is equal to the field.
- R4: Bit 5 of the flag register (alarm) is set at the clock edge where `upd_tick` is high and all three fields match. A match without `upd_tick` sets nothing.
- R5: `per_tick` sets bit 6 (periodic) and `upd_tick` sets bit 4 (update-ended) at the next clock edge.
- R6: The three source flags latch whatever their enables are, and they stay set until the host clears them.
- R7: Bit 7 of the flag register and `irq` are high exactly when at least one source flag is set together with its enable.
- R8: A read at address 12 returns the flags as they are before the edge, and clears all of them at that edge.
- R9: An event that arrives in the same cycle as a clearing read leaves its flag set after the edge.
- R10: Reads at other addresses do not change the flags, and a write to address 12 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read at address 12 clears the flags) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| cur_sec | input | 8 | Current seconds value |
| cur_min | input | 8 | Current minutes value |
| cur_hour | input | 8 | Current hours value |
| per_tick | input | 1 | Periodic event pulse |
| upd_tick | input | 1 | Update-ended pulse; alarm comparison instant |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is the collision of an event with a clearing read of the flag register. Behind it sits a full three-field alarm hit that lands on the exact cycle of an update pulse. The stimulus draws the time values and the alarm bytes from a very small range, with the match-all code mixed in, so that hits are frequent. It raises both pulses and flag reads often enough that they coincide many times. Directed cases place a periodic pulse on the same cycle as a flag read, and check that the read returns the old value while the flag survives.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int NUM_FIELDS = 3;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Register addresses seen by the host
    localparam addr_t ADR_ALM_SEC  = 4'd1;
    localparam addr_t ADR_ALM_MIN  = 4'd3;
    localparam addr_t ADR_ALM_HOUR = 4'd5;
    localparam addr_t ADR_CTRL     = 4'd11;
    localparam addr_t ADR_FLAGS    = 4'd12;

    // Field indices inside the packed alarm array
    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;

    // Event sources, in register bit order (6,5,4)
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_t;

    localparam logic [1:0] WILDCARD = 2'b11;

    function automatic logic field_hit(input byte_t alarm, input byte_t now);
        return (alarm[DATA_W-1 -: 2] == WILDCARD) || (alarm == now);
    endfunction

    function automatic byte_t pack_src(input logic top, input src_t s);
        return {top, s.per, s.alm, s.upd, 4'b0000};
    endfunction

endpackage

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_irq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  addr_t                        addr,
    input  byte_t                        wdata,
    output byte_t [NUM_FIELDS-1:0]       alarm,
    output src_t                         en
);

    byte_t [NUM_FIELDS-1:0] alarm_q;
    src_t                   en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            case (addr)
                ADR_ALM_SEC:  alarm_q[FLD_SEC]  <= wdata;
                ADR_ALM_MIN:  alarm_q[FLD_MIN]  <= wdata;
                ADR_ALM_HOUR: alarm_q[FLD_HOUR] <= wdata;
                ADR_CTRL:     en_q <= src_t'(wdata[6:4]);
                default: ;
            endcase
        end
    end

    assign alarm = alarm_q;
    assign en    = en_q;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_irq_pkg::*;
(
    input  byte_t [NUM_FIELDS-1:0] alarm,
    input  byte_t [NUM_FIELDS-1:0] now,
    output logic                   all_hit
);

    logic [NUM_FIELDS-1:0] hit;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign hit[i] = field_hit(alarm[i], now[i]);
    end

    assign all_hit = &hit;

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_t set,
    input  logic clr,
    output src_t flags
);

    src_t flags_q;
    src_t flags_d;

    // Set wins over clear so no event is lost
    always_comb begin
        flags_d = src_t'(set | (flags_q & {$bits(src_t){~clr}}));
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic       per_tick,
    input  logic       upd_tick,
    output logic       irq
);

    byte_t [NUM_FIELDS-1:0] alarm_w;
    byte_t [NUM_FIELDS-1:0] now_w;
    src_t                   en_q;
    src_t                   flags_q;
    src_t                   set_w;
    logic                   all_hit;
    logic                   clr_w;
    logic                   any_w;
    byte_t                  rd_mux;

    assign now_w[FLD_SEC]  = cur_sec;
    assign now_w[FLD_MIN]  = cur_min;
    assign now_w[FLD_HOUR] = cur_hour;

    rtc_host_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .alarm (alarm_w),
        .en    (en_q)
    );

    rtc_alarm_match u_match (
        .alarm   (alarm_w),
        .now     (now_w),
        .all_hit (all_hit)
    );

    always_comb begin
        set_w.per = per_tick;
        set_w.alm = upd_tick & all_hit;
        set_w.upd = upd_tick;
    end

    assign clr_w = rd_en && (addr == ADR_FLAGS);

    rtc_flag_unit u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (set_w),
        .clr   (clr_w),
        .flags (flags_q)
    );

    assign any_w = |(flags_q & en_q);
    assign irq   = any_w;

    always_comb begin
        case (addr)
            ADR_ALM_SEC:  rd_mux = alarm_w[FLD_SEC];
            ADR_ALM_MIN:  rd_mux = alarm_w[FLD_MIN];
            ADR_ALM_HOUR: rd_mux = alarm_w[FLD_HOUR];
            ADR_CTRL:     rd_mux = pack_src(1'b0, en_q);
            ADR_FLAGS:    rd_mux = pack_src(any_w, flags_q);
            default:      rd_mux = '0;
        endcase
        rdata = rd_en ? rd_mux : '0;
    end

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
    import rtc_irq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic [3:0] addr,
    input logic       per_tick,
    input logic       upd_tick,
    input logic       irq,
    input src_t       flags,
    input src_t       en
);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0 && !irq));

    a_r5_periodic_latches: assert property (@(posedge clk) disable iff (rst)
        per_tick |=> flags.per);

    a_r5_update_latches: assert property (@(posedge clk) disable iff (rst)
        upd_tick |=> flags.upd);

    a_r4_alarm_needs_update: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.alm) |-> $past(upd_tick));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADR_FLAGS && !per_tick && !upd_tick) |=> flags == '0);

    a_r7_irq_needs_enabled_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & en) != '0));

    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!(rd_en && addr == ADR_FLAGS) && !per_tick && !upd_tick) |=> $stable(flags));

endmodule

bind rtc_alarm_irq rtc_irq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .per_tick (per_tick),
    .upd_tick (upd_tick),
    .irq      (irq),
    .flags    (flags_q),
    .en       (en_q)
);

// File: tb/rtc_alarm_irq_bench.sv
`timescale 1ns/1ps
module rtc_alarm_irq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic       per_tick = 1'b0, upd_tick = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // model state
    logic [7:0] m_alm [3];
    logic [2:0] m_en;   // {per, alm, upd}
    logic [2:0] m_flg;  // {per, alm, upd}

    always #2 clk = ~clk;

    rtc_alarm_irq u_rtc_alarm_irq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .per_tick(per_tick), .upd_tick(upd_tick), .irq(irq)
    );

    function automatic logic fld_ok(input logic [7:0] a, input logic [7:0] n);
        return (a[7:6] == 2'b11) || (a == n);
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'd1:  return m_alm[0];
            4'd3:  return m_alm[1];
            4'd5:  return m_alm[2];
            4'd11: return {1'b0, m_en, 4'b0};
            4'd12: return {|(m_flg & m_en), m_flg, 4'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive, check read, advance model, check irq
    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] wd, input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic p, input logic u,
                        input string tag);
        logic [7:0] e;
        logic       hit;
        wr_en = wr; rd_en = rd; addr = a; wdata = wd;
        cur_sec = s; cur_min = m; cur_hour = h; per_tick = p; upd_tick = u;
        #1;
        e = rd ? exp_read(a) : 8'h00;
        check(rdata == e, tag, rdata, e);
        hit = u && fld_ok(m_alm[0], s) && fld_ok(m_alm[1], m) && fld_ok(m_alm[2], h);
        @(posedge clk);
        m_flg = {p, hit, u} | (m_flg & {3{~(rd && a == 4'd12)}});
        if (wr) begin
            case (a)
                4'd1:  m_alm[0] = wd;
                4'd3:  m_alm[1] = wd;
                4'd5:  m_alm[2] = wd;
                4'd11: m_en = wd[6:4];
                default: ;
            endcase
        end
        @(negedge clk);
        check(irq == |(m_flg & m_en), {tag, " R7 irq"}, {7'b0, irq},
              {7'b0, |(m_flg & m_en)});
        wr_en = 1'b0; rd_en = 1'b0; per_tick = 1'b0; upd_tick = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b0, 1'b1, a, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        m_alm = '{8'h00, 8'h00, 8'h00};
        m_en = '0;
        m_flg = '0;
        seed = 32'd7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(irq == 1'b0, "R1 irq", {7'b0, irq}, 8'h00);
        rd(4'd12, "R1 flags");
        rd(4'd1, "R1 alarm sec");
        rd(4'd11, "R1 ctrl");

        // R2 register write/readback
        wr(4'd1, 8'h10, "R2");
        wr(4'd3, 8'h20, "R2");
        wr(4'd5, 8'h08, "R2");
        wr(4'd11, 8'hFF, "R2");
        rd(4'd1, "R2 sec");
        rd(4'd3, "R2 min");
        rd(4'd5, "R2 hour");
        rd(4'd11, "R2 ctrl");
        rd(4'd7, "R2 unmapped");
        wr(4'd11, 8'h00, "R2");

        // R4 match without update sets nothing
        step(0, 0, 0, 0, 8'h10, 8'h20, 8'h08, 0, 0, "R4 no update");
        rd(4'd12, "R4 no flag");
        // R4 match with update sets alarm and update flags
        step(0, 0, 0, 0, 8'h10, 8'h20, 8'h08, 0, 1, "R4 hit");
        rd(4'd12, "R4 read 0x30");
        // R4 mismatch in one field
        step(0, 0, 0, 0, 8'h10, 8'h21, 8'h08, 0, 1, "R4 miss");
        rd(4'd12, "R4 read 0x10");

        // R3 wildcard
        wr(4'd1, 8'hC5, "R3");
        step(0, 0, 0, 0, 8'h37, 8'h20, 8'h08, 0, 1, "R3 wildcard");
        rd(4'd12, "R3 read");
        wr(4'd1, 8'h85, "R3");
        step(0, 0, 0, 0, 8'h37, 8'h20, 8'h08, 0, 1, "R3 not wildcard");
        rd(4'd12, "R3 read no alarm");

        // R5 and R6 periodic latches with enables off
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R5 periodic");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 hold");
        rd(4'd12, "R6 latched 0x40");

        // R7 enable
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R5 periodic");
        wr(4'd11, 8'h40, "R7 enable per");
        rd(4'd12, "R7 read 0xC0");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 upd masked");
        rd(4'd12, "R7 read 0x10");

        // R9 event during clearing read
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 setup");
        step(0, 1, 4'd12, 0, 0, 0, 0, 1, 0, "R9 read with event");
        rd(4'd12, "R9 survived");
        rd(4'd12, "R8 cleared");

        // R10 non-clearing accesses
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 setup");
        rd(4'd3, "R10 other read");
        wr(4'd12, 8'hFF, "R10 write ignored");
        rd(4'd12, "R10 flags intact");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            int unsigned r;
            r = $urandom % 8;
            case (r)
                0: a = 4'd1; 1: a = 4'd3; 2: a = 4'd5; 3: a = 4'd11;
                4, 5: a = 4'd12; 6: a = 4'd0; default: a = 4'd9;
            endcase
            d = ($urandom % 4 == 0) ? (8'hC0 | 8'($urandom % 4)) : 8'($urandom % 3);
            if (a == 4'd11) d = 8'($urandom);
            step(($urandom % 6) == 0, ($urandom % 3) == 0, a, d,
                 8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3),
                 ($urandom % 5) == 0, ($urandom % 3) == 0, "R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule